// File: doc/BRIEF.md
# Drive Output Control Register

This block is the 8-bit control register that a floppy disk controller exposes to the host for the drive interface. The host writes a control byte through a simple write strobe and reads back the stored byte. The byte holds four motor-on bits, one enable that gates the controller's DMA request and interrupt lines, an active-low bit that holds the rest of the controller in reset, and a two-bit binary drive number.

The register turns that byte into drive-side signals. The motor enables come straight from the stored bits. The drive number is decoded into four active-low select lines, and a select line only asserts when the matching motor bit is also set. The DMA request and interrupt from the controller core pass through only while the enable bit is set. The controller reset output is a level. It stays high while the reset bit holds 0, and then for a fixed number of extra cycles after a 1 is written. Two back-to-back writes of 0 then 1 therefore give a pulse that is long enough. The software reset never clears this register.

Top module: `drive_ctl_reg`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, the stored byte is 0x00. So `rd_data_o` = 0x00, `motor_en_o` = 0, `drive_sel_n_o` = 4'b1111, `dma_en_o` = 0 and `ctl_rst_o` = 1.
- R2: A write (`wr_en_i` high at a rising edge) stores `wr_data_i`, and `rd_data_o` shows it unchanged from the next cycle on. This holds in any cycle, including while the controller reset is asserted.
- R3: The outputs follow the byte's fields. `motor_en_o[i]` equals bit 4+i for i = 0..3, and `dma_en_o` equals bit 3.
- R4: Bits 1:0 are a binary drive number d. `drive_sel_n_o[d]` is 0 exactly when motor bit 4+d is 1. Every other select line is 1, so at most one select line is low.
- R5: While bit 2 of the stored byte is 0, `ctl_rst_o` is 1.
- R6: After bit 2 returns to 1, `ctl_rst_o` stays 1 for exactly `RST_HOLD` more cycles and then falls. A write of 0 followed in the next cycle by a write of 1 gives a pulse of `RST_HOLD`+1 cycles, which is 26 cycles at the defaults (104 ns with a 4 ns clock).
- R7: An asserted controller reset leaves the stored byte and all other outputs unchanged.
- R8: `dma_req_o` = `dma_req_i` AND bit 3, and `irq_o` = `irq_i` AND bit 3. Both are 0 whenever bit 3 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| wr_en_i | input | 1 | Host write strobe |
| wr_data_i | input | 8 | Host write byte |
| rd_data_o | output | 8 | Stored byte for host reads |
| motor_en_o | output | 4 | Motor enables, drive 3 to 0 |
| drive_sel_n_o | output | 4 | Decoded drive selects, active low |
| dma_en_o | output | 1 | DMA/interrupt enable bit |
| ctl_rst_o | output | 1 | Reset level for the rest of the controller |
| dma_req_i | input | 1 | DMA request from the controller core |
| irq_i | input | 1 | Interrupt from the controller core |
| dma_req_o | output | 1 | Gated DMA request |
| irq_o | output | 1 | Gated interrupt |

## Verification
A corrupted stored byte shows up on `rd_data_o` and on the motor and select lines one cycle after the write that should have set it, so a sweep of all 256 byte values exposes any swapped field or decode error right away. A wrong hold counter cannot be seen in the first cycle. It shows only as a reset pulse that is shorter or longer than `RST_HOLD` extra cycles, or as a reset that never falls, so the bench measures the pulse width edge by edge. A software reset that wrongly cleared state would change the read-back byte in the cycle after the reset bit is written to 0.

// File: rtl/drive_ctl_pkg.sv
package drive_ctl_pkg;

    localparam int DRIVES = 4;
    localparam int SEL_W  = $clog2(DRIVES);
    localparam int REG_W  = DRIVES + 2 + SEL_W;

    // Field order is the host-visible byte layout, MSB first.
    typedef struct packed {
        logic [DRIVES-1:0] motor;
        logic              dma_en;
        logic              run;      // 0 = controller held in reset
        logic [SEL_W-1:0]  drive;
    } ctl_word_t;

    function automatic ctl_word_t to_word(input logic [REG_W-1:0] raw);
        return ctl_word_t'(raw);
    endfunction

    function automatic logic select_hit(input logic [SEL_W-1:0] drive,
                                        input int unsigned      idx,
                                        input logic             motor_on);
        return (drive == SEL_W'(idx)) && motor_on;
    endfunction

endpackage

// File: rtl/drive_ctl_store.sv
module drive_ctl_store
    import drive_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output ctl_word_t        word
);

    // Only the hardware reset clears the byte; the software reset bit is data.
    always_ff @(posedge clk) begin
        if (rst) begin
            word <= '0;
        end else if (wr_en) begin
            word <= to_word(wr_data);
        end
    end

endmodule

// File: rtl/drive_ctl_decode.sv
module drive_ctl_decode
    import drive_ctl_pkg::*;
(
    input  ctl_word_t         word,
    output logic [DRIVES-1:0] sel_n
);

    for (genvar i = 0; i < DRIVES; i++) begin : g_sel
        assign sel_n[i] = !select_hit(word.drive, i, word.motor[i]);
    end

endmodule

// File: rtl/drive_ctl_rstgen.sv
module drive_ctl_rstgen #(
    parameter int HOLD = 25
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic ctl_rst
);

    localparam int CNT_W = $clog2(HOLD + 1);
    localparam logic [CNT_W-1:0] HOLD_V = CNT_W'(HOLD);

    logic [CNT_W-1:0] remain;

    // Reloaded while the reset bit is low; counts the tail once it is high.
    always_ff @(posedge clk) begin
        if (rst || !run) begin
            remain <= HOLD_V;
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign ctl_rst = !run || (remain != '0);

endmodule

// File: rtl/drive_ctl_reg.sv
module drive_ctl_reg
    import drive_ctl_pkg::*;
#(
    parameter int RST_HOLD = 25
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_i,
    input  logic [REG_W-1:0]  wr_data_i,
    output logic [REG_W-1:0]  rd_data_o,
    output logic [DRIVES-1:0] motor_en_o,
    output logic [DRIVES-1:0] drive_sel_n_o,
    output logic              dma_en_o,
    output logic              ctl_rst_o,
    input  logic              dma_req_i,
    input  logic              irq_i,
    output logic              dma_req_o,
    output logic              irq_o
);

    ctl_word_t word;

    drive_ctl_store u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en_i),
        .wr_data (wr_data_i),
        .word    (word)
    );

    drive_ctl_decode u_decode (
        .word  (word),
        .sel_n (drive_sel_n_o)
    );

    drive_ctl_rstgen #(.HOLD(RST_HOLD)) u_rstgen (
        .clk     (clk),
        .rst     (rst),
        .run     (word.run),
        .ctl_rst (ctl_rst_o)
    );

    assign rd_data_o  = word;
    assign motor_en_o = word.motor;
    assign dma_en_o   = word.dma_en;
    assign dma_req_o  = dma_req_i && word.dma_en;
    assign irq_o      = irq_i && word.dma_en;

endmodule

// File: rtl/drive_ctl_reg_chk.sv
module drive_ctl_reg_chk #(
    parameter int HOLD = 25
) (
    input logic       clk,
    input logic       rst,
    input logic       wr_en_i,
    input logic [7:0] wr_data_i,
    input logic [7:0] rd_data_o,
    input logic [3:0] motor_en_o,
    input logic [3:0] drive_sel_n_o,
    input logic       dma_en_o,
    input logic       ctl_rst_o,
    input logic       dma_req_o,
    input logic       irq_o
);

    logic [31:0] high_run;

    always_ff @(posedge clk) begin
        if (rst || !ctl_rst_o) begin
            high_run <= '0;
        end else if (high_run != 32'hFFFF_FFFF) begin
            high_run <= high_run + 1;
        end
    end

    // R2
    wr_readback_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en_i |=> rd_data_o == $past(wr_data_i));

    // R4
    sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~drive_sel_n_o));

    // R4
    sel_motor_chk: assert property (@(posedge clk) disable iff (rst)
        (drive_sel_n_o != 4'hF) |-> (motor_en_o[rd_data_o[1:0]] && !drive_sel_n_o[rd_data_o[1:0]]));

    // R5
    swrst_level_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_data_o[2] |-> ctl_rst_o);

    // R6
    swrst_width_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ctl_rst_o) |-> high_run >= 32'(HOLD));

    // R7
    swrst_keeps_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_rst_o && !wr_en_i) |=> $stable(rd_data_o) && $stable(motor_en_o) && $stable(dma_en_o));

    // R8
    dma_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !dma_en_o |-> (!dma_req_o && !irq_o));

endmodule

bind drive_ctl_reg drive_ctl_reg_chk #(.HOLD(RST_HOLD)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .wr_en_i       (wr_en_i),
    .wr_data_i     (wr_data_i),
    .rd_data_o     (rd_data_o),
    .motor_en_o    (motor_en_o),
    .drive_sel_n_o (drive_sel_n_o),
    .dma_en_o      (dma_en_o),
    .ctl_rst_o     (ctl_rst_o),
    .dma_req_o     (dma_req_o),
    .irq_o         (irq_o)
);

// File: tb/drive_ctl_reg_test.sv
`timescale 1ns/1ps
module drive_ctl_reg_test;

    localparam int HOLD = 25;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en_i = 1'b0;
    logic [7:0] wr_data_i = '0;
    logic [7:0] rd_data_o;
    logic [3:0] motor_en_o;
    logic [3:0] drive_sel_n_o;
    logic       dma_en_o;
    logic       ctl_rst_o;
    logic       dma_req_i = 1'b1;
    logic       irq_i = 1'b1;
    logic       dma_req_o;
    logic       irq_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    drive_ctl_reg #(.RST_HOLD(HOLD)) uut (
        .clk           (clk),
        .rst           (rst),
        .wr_en_i       (wr_en_i),
        .wr_data_i     (wr_data_i),
        .rd_data_o     (rd_data_o),
        .motor_en_o    (motor_en_o),
        .drive_sel_n_o (drive_sel_n_o),
        .dma_en_o      (dma_en_o),
        .ctl_rst_o     (ctl_rst_o),
        .dma_req_i     (dma_req_i),
        .irq_i         (irq_i),
        .dma_req_o     (dma_req_o),
        .irq_o         (irq_o)
    );

    task automatic check(input logic ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_sel_n(input logic [7:0] v);
        logic [3:0] s = 4'hF;
        int d = int'(v[1:0]);
        if (v[4 + d]) s[d] = 1'b0;
        return s;
    endfunction

    task automatic write(input logic [7:0] v);
        @(negedge clk);
        wr_en_i   = 1'b1;
        wr_data_i = v;
        @(negedge clk);
        wr_en_i   = 1'b0;
    endtask

    task automatic check_fields(input logic [7:0] v, input string req);
        check(rd_data_o == v, "R2", {req, " readback"}, rd_data_o, v);
        check(motor_en_o == v[7:4], "R3", {req, " motor"}, motor_en_o, v[7:4]);
        check(dma_en_o == v[3], "R3", {req, " dma_en"}, dma_en_o, v[3]);
        check(drive_sel_n_o == exp_sel_n(v), "R4", {req, " select"}, drive_sel_n_o, exp_sel_n(v));
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(rd_data_o == 8'h00 && motor_en_o == 4'h0 && dma_en_o == 1'b0,
              "R1", "in reset regs", rd_data_o, 0);
        check(drive_sel_n_o == 4'hF, "R1", "in reset select", drive_sel_n_o, 4'hF);
        check(ctl_rst_o == 1'b1, "R1", "in reset ctl_rst", ctl_rst_o, 1);
        rst = 1'b0;
        @(negedge clk);
        check(rd_data_o == 8'h00 && ctl_rst_o == 1'b1, "R1", "after reset", rd_data_o, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic prev_run;
        int   width;

        do_reset();

        // Full sweep of the byte; the gap lets each reset tail expire.
        prev_run = 1'b0;
        for (int v = 0; v < 256; v++) begin
            logic [7:0] b = 8'(v);
            write(b);
            check_fields(b, "sweep");
            check(dma_req_o == b[3] && irq_o == b[3], "R8", "gate inputs high",
                  {dma_req_o, irq_o}, {b[3], b[3]});
            if (!b[2]) begin
                check(ctl_rst_o == 1'b1, "R5", "bit2 low", ctl_rst_o, 1);
            end else if (!prev_run) begin
                check(ctl_rst_o == 1'b1, "R6", "tail after 0->1", ctl_rst_o, 1);
            end else begin
                check(ctl_rst_o == 1'b0, "R6", "no tail 1->1", ctl_rst_o, 0);
            end
            repeat (HOLD + 2) @(negedge clk);
            check(ctl_rst_o == !b[2], "R6", "settled reset level", ctl_rst_o, !b[2]);
            check(rd_data_o == b, "R7", "held after wait", rd_data_o, b);
            prev_run = b[2];
        end

        // Gate pass-through with every input pattern, enable on and off.
        for (int e = 0; e < 2; e++) begin
            write(e[0] ? 8'h0C : 8'h04);
            for (int p = 0; p < 4; p++) begin
                dma_req_i = p[0];
                irq_i     = p[1];
                #1;
                check(dma_req_o == (p[0] && e[0]), "R8", "dma_req gate", dma_req_o, p[0] && e[0]);
                check(irq_o == (p[1] && e[0]), "R8", "irq gate", irq_o, p[1] && e[0]);
            end
        end
        dma_req_i = 1'b1;
        irq_i     = 1'b1;

        // Back-to-back 0 then 1: pulse width measured per cycle.
        write(8'h04);
        repeat (HOLD + 2) @(negedge clk);
        check(ctl_rst_o == 1'b0, "R6", "idle before pulse", ctl_rst_o, 0);
        @(negedge clk);
        wr_en_i   = 1'b1;
        wr_data_i = 8'h00;
        @(negedge clk);
        wr_data_i = 8'h04;
        width = ctl_rst_o ? 1 : 0;
        for (int k = 0; k < HOLD + 8; k++) begin
            @(negedge clk);
            if (k == 0) wr_en_i = 1'b0;
            if (ctl_rst_o) width++;
        end
        check(width == HOLD + 1, "R6", "pulse width", width, HOLD + 1);

        // Software reset keeps the byte; writes during reset still land.
        write(8'hF6);
        repeat (HOLD + 2) @(negedge clk);
        write(8'hF2);
        check_fields(8'hF2, "R7 enter swrst");
        check(ctl_rst_o == 1'b1, "R5", "swrst entered", ctl_rst_o, 1);
        repeat (5) @(negedge clk);
        check(rd_data_o == 8'hF2 && motor_en_o == 4'hF, "R7", "swrst holds byte", rd_data_o, 8'hF2);
        write(8'h31);
        check_fields(8'h31, "R2 write in swrst");
        check(ctl_rst_o == 1'b1, "R5", "still in swrst", ctl_rst_o, 1);

        // Hardware reset in the middle of operation clears everything.
        write(8'hFF);
        do_reset();

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule